// File: doc/BRIEF.md
# Indexed Socket Register Controller

This block is the host-facing register file of a card bridge that serves up to four card sockets. The host sees only two byte locations. A write to the first location (select low) loads an 8-bit index. The second location (select high) then reads or writes whichever register that index names. The top two index bits pick the socket bank. The low six bits pick a register inside that bank, so each bank spans 64 index values.

Each socket keeps its own set of registers:

- a read-only interface-status view of its card pins;
- a power setting;
- a general control byte, which includes the I/O-card mode bit;
- an enable mask for status changes;
- a latch of status changes, which is cleared by reading it.

Pin transitions set latch bits only where the matching enable bit is set. Which pin feeds which latch bit depends on the I/O-card mode. A per-event routing mask steers each latched event class to one of two interrupt outputs. A two-bit configuration input sets how many banks exist. Banks beyond that count read as zero, ignore writes and never raise an interrupt.

The index port is handled by a two-state sequencer. In `PORT_UNSET`, no index has been written since reset; data-port reads return zero and data-port writes are dropped. The only transition, `UNSET->SET`, fires on the first index write. In `PORT_SET`, data-port accesses reach the selected register, and later index writes keep the sequencer in `PORT_SET`.

Top module: `slot_regbank_top`

## Requirements
- R1: With `bus_sel`=0, a write loads the index and a read returns the current index. With `bus_sel`=1, accesses reach the register at offset index[5:0] of socket index[7:6]. Register contents of one socket are independent of every other socket.
- R2: `cfg_slots` sets the number of active sockets: 0 gives 2, 1 gives 1, 2 or 3 give 4. Sockets numbered at or above that count read 0x00, ignore writes, report no card, and latch no events. Register contents survive while a socket is inactive.
- R3: Offset 0x01 is read-only status. Bits 5:0 are `card_pins` of that socket (bit0 battery-1 or I/O status-change, bit1 battery-2, bits 2 and 3 the two card-detect pins, bit4 write-protect, bit5 ready). Bit6 copies power bit6. Bit7 reads 0.
- R4: `card_present[s]` is 1 only when socket s is active and both of its pin bits 2 and 3 are 1.
- R5: Offset 0x02 (power: bits 1:0 Vpp1, 3:2 Vpp2, 4 Vcc, 5 auto-power, 6 output-enable, 7 no-reset-on-resume) and offset 0x03 (control; bit5 selects I/O-card mode) are 8-bit read/write registers that reset to 0x00.
- R6: Offset 0x05 is the change-enable register. Bits 3:0 are stored and bits 7:4 read 0.
- R7: Latch bit k at offset 0x04 is set on any transition of its source while enable bit k is 1. The sources are: bit3, the card-detect condition (pin2 AND pin3); bit0, pin0; bit1, pin1 in memory mode only; bit2, pin5 in memory mode only. In I/O-card mode, pins 1 and 5 set nothing.
- R8: A data read of offset 0x04 returns the latch and clears it. An event arriving in the same cycle as that read stays latched.
- R9: `irq_pci` is the OR over active sockets of latch bits k with `route_mask[k]`=1. `irq_isa` is the same OR for bits with `route_mask[k]`=0. Both are 0 when nothing is latched.
- R10: Offsets other than 0x01 to 0x05 read 0x00 and ignore writes. Before the first index write after reset, data reads return 0x00 and data writes are ignored.
- R11: Read data is registered. `bus_rdata` changes only in the cycle after a read strobe and holds its value across writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_slots | input | 2 | Socket-count code |
| route_mask | input | 8 | Per-event interrupt steering, 1 = `irq_pci` |
| bus_sel | input | 1 | 0 = index location, 1 = data location |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| card_pins | input | 6*NUM_SLOTS | Card pins, 6 per socket |
| card_present | output | NUM_SLOTS | Card fully inserted, per socket |
| irq_pci | output | 1 | Interrupt for events steered to PCI-style routing |
| irq_isa | output | 1 | Interrupt for events steered to ISA-style routing |

## Verification
Register accesses use distinct values across sockets, so an error in the bank decode appears as data crossing into a neighbouring bank. The socket count is switched through all three codes to show that inactive banks hide their data but keep it.

Pin toggles are applied in both card modes, with the enable mask set and cleared. This separates the mode-dependent source mapping from the enable gating. One read of the latch is placed in the same cycle as a new event, which tells apart the two possible orderings of clear and set. The routing mask is flipped while an event is pending, which shows that each event class is steered on its own.

// File: rtl/slot_regbank_pkg.sv
package slot_regbank_pkg;
    localparam int IDX_W   = 8;
    localparam int OFS_W   = 6;
    localparam int DATA_W  = 8;
    localparam int PIN_W   = 6;
    localparam int EVT_W   = 4;
    localparam int SEL_W   = IDX_W - OFS_W;

    localparam logic [OFS_W-1:0] OFS_STAT = 6'h01;
    localparam logic [OFS_W-1:0] OFS_PWR  = 6'h02;
    localparam logic [OFS_W-1:0] OFS_CTRL = 6'h03;
    localparam logic [OFS_W-1:0] OFS_CHG  = 6'h04;
    localparam logic [OFS_W-1:0] OFS_ENA  = 6'h05;

    localparam int CTRL_IO_BIT = 5;
    localparam int PWR_OUT_BIT = 6;

    typedef enum logic {
        PORT_UNSET = 1'b0,
        PORT_SET   = 1'b1
    } port_state_e;

    function automatic logic [2:0] slots_for_cfg(input logic [1:0] code);
        logic [2:0] n;
        unique case (code)
            2'd0:    n = 3'd2;
            2'd1:    n = 3'd1;
            default: n = 3'd4;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/slot_port_fsm.sv
module slot_port_fsm
    import slot_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [IDX_W-1:0]  index_q,
    output port_state_e       state_q,
    output logic              acc_wr,
    output logic              acc_rd,
    output logic              idx_rd
);
    port_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_UNSET: if (bus_wr && !bus_sel) state_d = PORT_SET;
            PORT_SET:   state_d = PORT_SET;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PORT_UNSET;
        else        state_q <= state_d;
    end

    // index register
    always_ff @(posedge clk) begin
        if (!rst_n)                index_q <= '0;
        else if (bus_wr && !bus_sel) index_q <= bus_wdata;
    end

    // outputs
    always_comb begin
        acc_wr = 1'b0;
        acc_rd = 1'b0;
        idx_rd = bus_rd && !bus_sel;
        unique case (state_q)
            PORT_UNSET: begin
                acc_wr = 1'b0;
                acc_rd = 1'b0;
            end
            PORT_SET: begin
                acc_wr = bus_wr && bus_sel;
                acc_rd = bus_rd && bus_sel;
            end
        endcase
    end
endmodule

// File: rtl/slot_bank.sv
module slot_bank
    import slot_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OFS_W-1:0]  offset,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PIN_W-1:0]  pins,
    output logic [DATA_W-1:0] rdata,
    output logic [EVT_W-1:0]  chg_q,
    output logic [EVT_W-1:0]  ena_q,
    output logic              present
);
    logic [DATA_W-1:0] pwr_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [PIN_W-1:0]  prev_q;
    logic [EVT_W-1:0]  edge_ev;
    logic [EVT_W-1:0]  chg_d;
    logic              io_mode;
    logic              det_now;
    logic              det_prev;
    logic              wr_ok;
    logic              clr_chg;

    assign io_mode  = ctrl_q[CTRL_IO_BIT];
    assign det_now  = pins[2] & pins[3];
    assign det_prev = prev_q[2] & prev_q[3];
    assign present  = active & det_now;
    assign wr_ok    = active & wr_en;
    assign clr_chg  = active & rd_en & (offset == OFS_CHG);

    // transitions per event class, mapping depends on card mode
    always_comb begin
        edge_ev[0] = pins[0] ^ prev_q[0];
        edge_ev[1] = ~io_mode & (pins[1] ^ prev_q[1]);
        edge_ev[2] = ~io_mode & (pins[5] ^ prev_q[5]);
        edge_ev[3] = det_now ^ det_prev;
    end

    always_comb begin
        if (!active) chg_d = '0;
        else         chg_d = (clr_chg ? '0 : chg_q) | (edge_ev & ena_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q  <= '0;
            ctrl_q <= '0;
            ena_q  <= '0;
            chg_q  <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= pins;
            chg_q  <= chg_d;
            if (wr_ok) begin
                case (offset)
                    OFS_PWR:  pwr_q  <= wdata;
                    OFS_CTRL: ctrl_q <= wdata;
                    OFS_ENA:  ena_q  <= wdata[EVT_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (active) begin
            case (offset)
                OFS_STAT: rdata = {1'b0, pwr_q[PWR_OUT_BIT], pins};
                OFS_PWR:  rdata = pwr_q;
                OFS_CTRL: rdata = ctrl_q;
                OFS_CHG:  rdata = {{(DATA_W-EVT_W){1'b0}}, chg_q};
                OFS_ENA:  rdata = {{(DATA_W-EVT_W){1'b0}}, ena_q};
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/slot_irq_route.sv
module slot_irq_route
    import slot_regbank_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic [NUM_SLOTS*EVT_W-1:0] chg_vec,
    input  logic [DATA_W-1:0]          route_mask,
    output logic                       irq_pci,
    output logic                       irq_isa
);
    logic [EVT_W-1:0] any_evt;

    always_comb begin
        any_evt = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            any_evt = any_evt | chg_vec[s*EVT_W +: EVT_W];
        end
    end

    assign irq_pci = |(any_evt &  route_mask[EVT_W-1:0]);
    assign irq_isa = |(any_evt & ~route_mask[EVT_W-1:0]);
endmodule

// File: rtl/slot_regbank_top.sv
module slot_regbank_top
    import slot_regbank_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 cfg_slots,
    input  logic [DATA_W-1:0]          route_mask,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_SLOTS*PIN_W-1:0] card_pins,
    output logic [NUM_SLOTS-1:0]       card_present,
    output logic                       irq_pci,
    output logic                       irq_isa
);
    logic [IDX_W-1:0]             index_q;
    port_state_e                  port_state;
    logic                         acc_wr;
    logic                         acc_rd;
    logic                         idx_rd;
    logic [2:0]                   slot_cnt;
    logic [NUM_SLOTS-1:0]         act;
    logic [NUM_SLOTS-1:0]         hit;
    logic [NUM_SLOTS*DATA_W-1:0]  bank_rd;
    logic [NUM_SLOTS*EVT_W-1:0]   chg_vec;
    logic [NUM_SLOTS*EVT_W-1:0]   en_vec;
    logic [DATA_W-1:0]            sel_data;
    logic [DATA_W-1:0]            rdata_q;
    logic                         port_unset;

    assign slot_cnt   = slots_for_cfg(cfg_slots);
    assign port_unset = (port_state == PORT_UNSET);

    slot_port_fsm u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .index_q   (index_q),
        .state_q   (port_state),
        .acc_wr    (acc_wr),
        .acc_rd    (acc_rd),
        .idx_rd    (idx_rd)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_bank
        assign act[s] = (3'(s) < slot_cnt);
        assign hit[s] = (index_q[IDX_W-1:OFS_W] == SEL_W'(s));

        slot_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (act[s]),
            .wr_en   (acc_wr & hit[s]),
            .rd_en   (acc_rd & hit[s]),
            .offset  (index_q[OFS_W-1:0]),
            .wdata   (bus_wdata),
            .pins    (card_pins[s*PIN_W +: PIN_W]),
            .rdata   (bank_rd[s*DATA_W +: DATA_W]),
            .chg_q   (chg_vec[s*EVT_W +: EVT_W]),
            .ena_q   (en_vec[s*EVT_W +: EVT_W]),
            .present (card_present[s])
        );
    end

    always_comb begin
        sel_data = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (hit[s]) sel_data = bank_rd[s*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            if (idx_rd)      rdata_q <= index_q;
            else if (acc_rd) rdata_q <= sel_data;
            else             rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;

    slot_irq_route #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
        .chg_vec    (chg_vec),
        .route_mask (route_mask),
        .irq_pci    (irq_pci),
        .irq_isa    (irq_isa)
    );
endmodule

// File: rtl/slot_regbank_chk.sv
module slot_regbank_chk
    import slot_regbank_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_rd,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic                       irq_pci,
    input logic                       irq_isa,
    input logic [NUM_SLOTS*EVT_W-1:0] chg_vec,
    input logic [NUM_SLOTS*EVT_W-1:0] en_vec,
    input logic [NUM_SLOTS-1:0]       act,
    input logic                       port_unset
);
    logic [NUM_SLOTS*EVT_W-1:0] act_x;

    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) act_x[s*EVT_W +: EVT_W] = {EVT_W{act[s]}};
    end

    // R11: read data moves only after a read strobe
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R10: data reads before any index write give zero
    p_unset_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (port_unset && bus_rd && bus_sel) |=> (bus_rdata == '0));

    // R7: a latch bit only rises where its enable was set
    p_latch_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((chg_vec & ~$past(chg_vec) & ~$past(en_vec)) == '0));

    // R2: a socket inactive for two cycles holds nothing
    p_inactive_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((chg_vec & ~act_x & ~$past(act_x)) == '0));

    // R9: no interrupt without a latched event
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_vec == '0) |-> (!irq_pci && !irq_isa));
endmodule

bind slot_regbank_top slot_regbank_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .irq_pci    (irq_pci),
    .irq_isa    (irq_isa),
    .chg_vec    (chg_vec),
    .en_vec     (en_vec),
    .act        (act),
    .port_unset (port_unset)
);

// File: tb/slot_regbank_tb.sv
module slot_regbank_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_slots = 2'd0;
    logic [7:0]  route_mask = 8'hFF;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [23:0] card_pins = '0;
    logic [3:0]  card_present;
    logic        irq_pci;
    logic        irq_isa;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    slot_regbank_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_slots    (cfg_slots),
        .route_mask   (route_mask),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .card_pins    (card_pins),
        .card_present (card_present),
        .irq_pci      (irq_pci),
        .irq_isa      (irq_isa)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [7:0] v);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic sel, output logic [7:0] v);
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] v);
        bus_write(1'b0, idx);
        bus_write(1'b1, v);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] v);
        bus_write(1'b0, idx);
        bus_read(1'b1, v);
    endtask

    task automatic set_pins(input int s, input logic [5:0] v);
        @(negedge clk);
        card_pins[s*6 +: 6] = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R11 reset rdata", bus_rdata, 8'h00);
        chk("R9 reset irq", {6'd0, irq_pci, irq_isa}, 8'h00);
        chk("R4 reset present", {4'd0, card_present}, 8'h00);
        bus_read(1'b1, v);
        chk("R10 read before index", v, 8'h00);
        bus_write(1'b1, 8'h55);
        reg_rd(8'h02, v);
        chk("R10 write before index dropped", v, 8'h00);
    endtask

    task automatic t_banks;
        logic [7:0] v;
        reg_wr(8'h42, 8'hA5);
        reg_rd(8'h42, v);
        chk("R1 socket1 power", v, 8'hA5);
        reg_rd(8'h02, v);
        chk("R1 socket0 untouched", v, 8'h00);
        bus_read(1'b0, v);
        chk("R1 index readback", v, 8'h02);
        reg_wr(8'h03, 8'h2C);
        reg_rd(8'h03, v);
        chk("R5 control readback", v, 8'h2C);
    endtask

    task automatic t_count;
        logic [7:0] v;
        reg_wr(8'h82, 8'h33);
        reg_rd(8'h82, v);
        chk("R2 socket2 inactive at 2", v, 8'h00);
        cfg_slots = 2'd3;
        reg_rd(8'h82, v);
        chk("R2 earlier write ignored", v, 8'h00);
        reg_wr(8'h82, 8'h33);
        reg_rd(8'h82, v);
        chk("R2 socket2 active at 4", v, 8'h33);
        cfg_slots = 2'd2;
        reg_wr(8'hC2, 8'h5A);
        reg_rd(8'hC2, v);
        chk("R2 socket3 active code 2", v, 8'h5A);
        cfg_slots = 2'd1;
        reg_rd(8'h42, v);
        chk("R2 socket1 inactive at 1", v, 8'h00);
        cfg_slots = 2'd0;
        reg_rd(8'h42, v);
        chk("R2 socket1 kept contents", v, 8'hA5);
    endtask

    task automatic t_status;
        logic [7:0] v;
        set_pins(0, 6'b001100);
        chk("R4 both detect", {4'd0, card_present}, 8'h01);
        reg_rd(8'h01, v);
        chk("R3 status pins", v, 8'h0C);
        set_pins(0, 6'b000100);
        chk("R4 one detect", {4'd0, card_present}, 8'h00);
        reg_rd(8'h01, v);
        chk("R3 status one pin", v, 8'h04);
        set_pins(0, 6'b001100);
        reg_wr(8'h02, 8'h40);
        reg_rd(8'h01, v);
        chk("R3 status power bit", v, 8'h4C);
    endtask

    task automatic t_misc;
        logic [7:0] v;
        reg_wr(8'h05, 8'hFF);
        reg_rd(8'h05, v);
        chk("R6 enable upper bits zero", v, 8'h0F);
        bus_write(1'b1, 8'h00);
        chk("R11 rdata held over write", bus_rdata, 8'h0F);
        reg_wr(8'h07, 8'h77);
        reg_rd(8'h07, v);
        chk("R10 unimplemented offset", v, 8'h00);
        reg_rd(8'h3F, v);
        chk("R10 top offset", v, 8'h00);
    endtask

    task automatic t_latch_mem;
        logic [7:0] v;
        reg_wr(8'h03, 8'h00);
        route_mask = 8'hFF;
        reg_wr(8'h05, 8'h0F);
        set_pins(0, 6'b001101);
        chk("R9 pin0 event to pci", {6'd0, irq_pci, irq_isa}, 8'h02);
        reg_rd(8'h04, v);
        chk("R8 latch read", v, 8'h01);
        chk("R8 irq after clear", {6'd0, irq_pci, irq_isa}, 8'h00);
        reg_rd(8'h04, v);
        chk("R8 second read empty", v, 8'h00);
        reg_wr(8'h05, 8'h01);
        set_pins(0, 6'b001111);
        chk("R7 disabled pin1 no irq", {6'd0, irq_pci, irq_isa}, 8'h00);
        reg_rd(8'h04, v);
        chk("R7 disabled pin1 no latch", v, 8'h00);
        // event in the same cycle as the clearing read
        bus_write(1'b0, 8'h04);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; card_pins[5:0] = 6'b001110;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R8 same-cycle read old value", bus_rdata, 8'h00);
        chk("R8 same-cycle event kept", {6'd0, irq_pci, irq_isa}, 8'h02);
        reg_rd(8'h04, v);
        chk("R8 same-cycle event read", v, 8'h01);
    endtask

    task automatic t_route;
        logic [7:0] v;
        reg_wr(8'h05, 8'h0F);
        route_mask = 8'h00;
        set_pins(0, 6'b101110);
        chk("R9 ready to isa", {6'd0, irq_pci, irq_isa}, 8'h01);
        route_mask = 8'h04;
        #1;
        chk("R9 ready to pci", {6'd0, irq_pci, irq_isa}, 8'h02);
        reg_rd(8'h04, v);
        chk("R7 ready in memory mode", v, 8'h04);
    endtask

    task automatic t_iomode;
        logic [7:0] v;
        route_mask = 8'hFF;
        reg_wr(8'h03, 8'h20);
        set_pins(0, 6'b101100);
        chk("R7 io mode pin1 ignored", {6'd0, irq_pci, irq_isa}, 8'h00);
        set_pins(0, 6'b001100);
        chk("R7 io mode pin5 ignored", {6'd0, irq_pci, irq_isa}, 8'h00);
        set_pins(0, 6'b001101);
        set_pins(0, 6'b000101);
        reg_rd(8'h04, v);
        chk("R7 io mode pin0 and detect", v, 8'h09);
    endtask

    task automatic t_inactive;
        logic [7:0] v;
        reg_wr(8'h45, 8'h0F);
        cfg_slots = 2'd1;
        set_pins(1, 6'b001101);
        chk("R2 inactive no irq", {6'd0, irq_pci, irq_isa}, 8'h00);
        chk("R4 inactive no present", {4'd0, card_present}, 8'h00);
        cfg_slots = 2'd0;
        #1;
        chk("R4 reactivated present", {4'd0, card_present}, 8'h02);
        reg_rd(8'h44, v);
        chk("R2 inactive latched nothing", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_banks();
        t_count();
        t_status();
        t_misc();
        t_latch_mem();
        t_route();
        t_iomode();
        t_inactive();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule